// File: doc/BRIEF.md
# Card Host Interrupt Status Register

This block holds the interrupt status flags of an MMC/SD card host controller. Internal events set flags in a 32-bit register. Software reads that register and clears flags by writing 1 to them. Error flags sit in bits [31:16] and normal flags in bits [15:0]. The block also contains the detection logic for four of the error flags.

- A bad-access flag sets when software touches the data buffer while the buffer does not permit it.
- A card-error flag sets from the masked card-status word of a decoded response.
- An auto-stop-command error flag sets on any new bit in that command's error vector.
- An end-bit error flag sets when the data path samples a 0 where a stop bit of 1 is expected.

The remaining error and normal flags are set by event strobes from other parts of the host. A single interrupt line reports any flag whose per-bit enable is high. Status changes on the clock edge that samples the event, so a flag is visible on the read port in the following cycle.

Top module: `cardhost_int_status`

## Requirements
- R1: After reset every status bit reads 0 and `irq_o` is low.
- R2: A write with bit n of `wr_data_i` equal to 1 clears status bit n. A write with bit n equal to 0 leaves bit n unchanged.
- R3: Bits 31:30, 27:25 and 23 always read 0, whatever is written and whatever events occur.
- R4: Bit 29 sets when `buf_rd_i` is high while `buf_rd_en_i` is low. It also sets when `buf_wr_i` is high while `buf_wr_en_i` is low. A permitted access does not set it.
- R5: Bit 28 sets when `rsp_valid_i` is high, `rsp_auto_stop_i` is low and `rsp_kind_i` codes a card-status response. Those codes are 1 (R1), 2 (R1b), 6 (R5), 7 (R5b) and 8 (R6). The bitwise AND of `rsp_status_i` and `cs_err_mask_i` must also be nonzero. Other codes, such as 3 (R2), and masked-off status bits do not set it.
- R6: A response flagged by `rsp_auto_stop_i` never sets bit 28.
- R7: Bit 24 sets when any bit of `ac12_err_i` goes from 0 to 1 relative to the previous cycle. The value taken as previous after reset is all zeros. A bit that stays high does not set the flag again after it is cleared.
- R8: Bit 22 sets when `eb_rd_valid_i` is high with `eb_rd_bit_i` at 0. It also sets when `eb_crc_valid_i` is high with `eb_crc_bit_i` at 0.
- R9: If a set event and a write-1 clear hit the same bit in the same cycle, the bit ends up 1.
- R10: Bit 15 reads as the OR of bits [31:16]. Writes do not change it.
- R11: `irq_o` is high exactly when the bitwise AND of the read value and `irq_en_i` is nonzero.
- R12: `ext_err_i[k]` sets bit 16+k, for k from 0 to 5. `norm_evt_i[k]` sets bit k, for k from 0 to 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Write data; 1 bits clear status |
| rd_data_o | output | 32 | Current status read value |
| buf_rd_i | input | 1 | Data-buffer read strobe |
| buf_wr_i | input | 1 | Data-buffer write strobe |
| buf_rd_en_i | input | 1 | Buffer read permitted |
| buf_wr_en_i | input | 1 | Buffer write permitted |
| rsp_valid_i | input | 1 | Decoded response strobe |
| rsp_kind_i | input | 4 | Response type code |
| rsp_auto_stop_i | input | 1 | Response belongs to an automatically issued stop command |
| rsp_status_i | input | CS_W | Card-status word of the response |
| cs_err_mask_i | input | CS_W | Per-bit enable of card-status error bits |
| ac12_err_i | input | AC12_W | Auto-stop-command error vector |
| eb_rd_valid_i | input | 1 | Read-data end-bit sample strobe |
| eb_rd_bit_i | input | 1 | Read-data end-bit value |
| eb_crc_valid_i | input | 1 | CRC-status end-bit sample strobe |
| eb_crc_bit_i | input | 1 | CRC-status end-bit value |
| ext_err_i | input | 6 | Other error event strobes (bits 21:16) |
| norm_evt_i | input | 15 | Normal event strobes (bits 14:0) |
| irq_en_i | input | 32 | Per-bit interrupt enable |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check the following rules on every cycle:
- The reserved bits stay 0.
- The summary bit and the interrupt line follow the read value.
- Every detected event appears on the read port one cycle later.
- Bits 29 and 28 never set without their cause, and a clear without a competing event leaves bit 29 at 0.

Some behaviour depends on history, and only the bench scenarios can show it:
- A held auto-stop error bit stays quiet once its flag is cleared.
- A write of 0 keeps a flag that was set earlier.
- Set and clear land in the same cycle.
- A masked or auto-stop response is rejected, including the response codes that carry no card status.

// File: rtl/cardhost_int_pkg.sv
package cardhost_int_pkg;
  localparam int STAT_W      = 32;
  localparam int BIT_BAD_ACC = 29;
  localparam int BIT_CARD    = 28;
  localparam int BIT_AC12    = 24;
  localparam int BIT_ENDBIT  = 22;
  localparam int BIT_SUMMARY = 15;
  localparam int EXT_LSB     = 16;
  localparam int EXT_W       = 6;
  localparam int NORM_W      = 15;
  localparam int ERR_LSB     = 16;

  localparam logic [STAT_W-1:0] RSV_MASK  = 32'hC000_0000 | 32'h0E00_0000 | 32'h0080_0000;
  localparam logic [STAT_W-1:0] SUM_MASK  = 32'h1 << BIT_SUMMARY;
  localparam logic [STAT_W-1:0] IMPL_MASK = ~(RSV_MASK | SUM_MASK);

  typedef enum logic [3:0] {
    RSP_NONE = 4'd0,
    RSP_R1   = 4'd1,
    RSP_R1B  = 4'd2,
    RSP_R2   = 4'd3,
    RSP_R3   = 4'd4,
    RSP_R4   = 4'd5,
    RSP_R5   = 4'd6,
    RSP_R5B  = 4'd7,
    RSP_R6   = 4'd8,
    RSP_R7   = 4'd9
  } rsp_kind_e;

  function automatic logic has_card_status(input logic [3:0] kind);
    case (rsp_kind_e'(kind))
      RSP_R1, RSP_R1B, RSP_R5, RSP_R5B, RSP_R6: has_card_status = 1'b1;
      default:                                  has_card_status = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/cardhost_rise_det.sv
module cardhost_rise_det #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] vec_i,
  output logic         rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= vec_i;
  end

  assign rise_o = |(vec_i & ~prev_q);
endmodule

// File: rtl/cardhost_err_detect.sv
module cardhost_err_detect
  import cardhost_int_pkg::*;
#(
  parameter int CS_W   = 32,
  parameter int AC12_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              buf_rd_i,
  input  logic              buf_wr_i,
  input  logic              buf_rd_en_i,
  input  logic              buf_wr_en_i,
  input  logic              rsp_valid_i,
  input  logic [3:0]        rsp_kind_i,
  input  logic              rsp_auto_stop_i,
  input  logic [CS_W-1:0]   rsp_status_i,
  input  logic [CS_W-1:0]   cs_err_mask_i,
  input  logic [AC12_W-1:0] ac12_err_i,
  input  logic              eb_rd_valid_i,
  input  logic              eb_rd_bit_i,
  input  logic              eb_crc_valid_i,
  input  logic              eb_crc_bit_i,
  output logic              bad_acc_o,
  output logic              card_err_o,
  output logic              ac12_err_o,
  output logic              endbit_err_o
);
  logic rd_bad, wr_bad;
  logic rsp_qualifies, status_hit;
  logic rd_eb_bad, crc_eb_bad;

  assign rd_bad    = buf_rd_i & ~buf_rd_en_i;
  assign wr_bad    = buf_wr_i & ~buf_wr_en_i;
  assign bad_acc_o = rd_bad | wr_bad;

  // auto-issued stop responses are never checked for card status
  assign rsp_qualifies = rsp_valid_i & ~rsp_auto_stop_i & has_card_status(rsp_kind_i);
  assign status_hit    = |(rsp_status_i & cs_err_mask_i);
  assign card_err_o    = rsp_qualifies & status_hit;

  cardhost_rise_det #(.W(AC12_W)) u_ac12_rise (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vec_i  (ac12_err_i),
    .rise_o (ac12_err_o)
  );

  assign rd_eb_bad    = eb_rd_valid_i & ~eb_rd_bit_i;
  assign crc_eb_bad   = eb_crc_valid_i & ~eb_crc_bit_i;
  assign endbit_err_o = rd_eb_bad | crc_eb_bad;
endmodule

// File: rtl/cardhost_stat_bank.sv
module cardhost_stat_bank #(
  parameter int          W         = 32,
  parameter logic [W-1:0] IMPL_MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_flop
      logic bit_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) bit_q <= 1'b0;
        else         bit_q <= (bit_q & ~clr_i[i]) | set_i[i]; // set beats clear
      end
      assign q_o[i] = bit_q;
    end else begin : g_rsv
      logic unused_in;
      assign unused_in = set_i[i] ^ clr_i[i];
      assign q_o[i]    = 1'b0;
    end
  end
endmodule

// File: rtl/cardhost_int_status.sv
module cardhost_int_status
  import cardhost_int_pkg::*;
#(
  parameter int CS_W   = 32,
  parameter int AC12_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [31:0]       wr_data_i,
  output logic [31:0]       rd_data_o,
  input  logic              buf_rd_i,
  input  logic              buf_wr_i,
  input  logic              buf_rd_en_i,
  input  logic              buf_wr_en_i,
  input  logic              rsp_valid_i,
  input  logic [3:0]        rsp_kind_i,
  input  logic              rsp_auto_stop_i,
  input  logic [CS_W-1:0]   rsp_status_i,
  input  logic [CS_W-1:0]   cs_err_mask_i,
  input  logic [AC12_W-1:0] ac12_err_i,
  input  logic              eb_rd_valid_i,
  input  logic              eb_rd_bit_i,
  input  logic              eb_crc_valid_i,
  input  logic              eb_crc_bit_i,
  input  logic [5:0]        ext_err_i,
  input  logic [14:0]       norm_evt_i,
  input  logic [31:0]       irq_en_i,
  output logic              irq_o
);
  logic bad_acc, card_err, ac12_err, endbit_err;
  logic [STAT_W-1:0] set_vec, clr_vec, stat_q, rd_val;
  logic summary;

  cardhost_err_detect #(.CS_W(CS_W), .AC12_W(AC12_W)) u_detect (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .buf_rd_i        (buf_rd_i),
    .buf_wr_i        (buf_wr_i),
    .buf_rd_en_i     (buf_rd_en_i),
    .buf_wr_en_i     (buf_wr_en_i),
    .rsp_valid_i     (rsp_valid_i),
    .rsp_kind_i      (rsp_kind_i),
    .rsp_auto_stop_i (rsp_auto_stop_i),
    .rsp_status_i    (rsp_status_i),
    .cs_err_mask_i   (cs_err_mask_i),
    .ac12_err_i      (ac12_err_i),
    .eb_rd_valid_i   (eb_rd_valid_i),
    .eb_rd_bit_i     (eb_rd_bit_i),
    .eb_crc_valid_i  (eb_crc_valid_i),
    .eb_crc_bit_i    (eb_crc_bit_i),
    .bad_acc_o       (bad_acc),
    .card_err_o      (card_err),
    .ac12_err_o      (ac12_err),
    .endbit_err_o    (endbit_err)
  );

  always_comb begin
    set_vec                     = '0;
    set_vec[NORM_W-1:0]         = norm_evt_i;
    set_vec[EXT_LSB +: EXT_W]   = ext_err_i;
    set_vec[BIT_ENDBIT]         = endbit_err;
    set_vec[BIT_AC12]           = ac12_err;
    set_vec[BIT_CARD]           = card_err;
    set_vec[BIT_BAD_ACC]        = bad_acc;
  end

  assign clr_vec = wr_en_i ? wr_data_i : '0;

  cardhost_stat_bank #(.W(STAT_W), .IMPL_MASK(IMPL_MASK)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .q_o    (stat_q)
  );

  assign summary = |stat_q[STAT_W-1:ERR_LSB];

  always_comb begin
    rd_val              = stat_q;
    rd_val[BIT_SUMMARY] = summary;
  end

  assign rd_data_o = rd_val;
  assign irq_o     = |(rd_val & irq_en_i);
endmodule

// File: rtl/cardhost_int_status_chk.sv
module cardhost_int_status_chk
  import cardhost_int_pkg::*;
#(
  parameter int CS_W   = 32,
  parameter int AC12_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [31:0]       wr_data_i,
  input logic [31:0]       rd_data_o,
  input logic              buf_rd_i,
  input logic              buf_wr_i,
  input logic              buf_rd_en_i,
  input logic              buf_wr_en_i,
  input logic              rsp_valid_i,
  input logic [3:0]        rsp_kind_i,
  input logic              rsp_auto_stop_i,
  input logic [CS_W-1:0]   rsp_status_i,
  input logic [CS_W-1:0]   cs_err_mask_i,
  input logic [AC12_W-1:0] ac12_err_i,
  input logic              eb_rd_valid_i,
  input logic              eb_rd_bit_i,
  input logic              eb_crc_valid_i,
  input logic              eb_crc_bit_i,
  input logic [31:0]       irq_en_i,
  input logic              irq_o
);
  logic [AC12_W-1:0] ac12_seen_q;
  logic bad_ev, card_ev, eb_ev, ac12_ev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ac12_seen_q <= '0;
    else         ac12_seen_q <= ac12_err_i;
  end

  assign bad_ev  = (buf_rd_i && !buf_rd_en_i) || (buf_wr_i && !buf_wr_en_i);
  assign card_ev = rsp_valid_i && !rsp_auto_stop_i &&
                   (rsp_kind_i inside {4'd1, 4'd2, 4'd6, 4'd7, 4'd8}) &&
                   ((rsp_status_i & cs_err_mask_i) != '0);
  assign eb_ev   = (eb_rd_valid_i && !eb_rd_bit_i) || (eb_crc_valid_i && !eb_crc_bit_i);
  assign ac12_ev = (ac12_err_i & ~ac12_seen_q) != '0;

  assert_rsv_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o & RSV_MASK) == '0);

  assert_bad_acc_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_ev |=> rd_data_o[BIT_BAD_ACC]);

  assert_bad_acc_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_data_o[BIT_BAD_ACC] && !bad_ev) |=> !rd_data_o[BIT_BAD_ACC]);

  assert_card_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_ev |=> rd_data_o[BIT_CARD]);

  // R6: without a non-auto response the card bit cannot rise
  assert_card_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_data_o[BIT_CARD] && !(rsp_valid_i && !rsp_auto_stop_i)) |=> !rd_data_o[BIT_CARD]);

  assert_ac12_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ac12_ev |=> rd_data_o[BIT_AC12]);

  assert_endbit_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eb_ev |=> rd_data_o[BIT_ENDBIT]);

  assert_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[BIT_BAD_ACC] && !bad_ev) |=> !rd_data_o[BIT_BAD_ACC]);

  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[BIT_ENDBIT] && eb_ev) |=> rd_data_o[BIT_ENDBIT]);

  assert_summary_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[BIT_SUMMARY] == (rd_data_o[31:16] != '0));

  assert_irq_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == ((rd_data_o & irq_en_i) != '0));
endmodule

bind cardhost_int_status cardhost_int_status_chk #(.CS_W(CS_W), .AC12_W(AC12_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .wr_en_i         (wr_en_i),
  .wr_data_i       (wr_data_i),
  .rd_data_o       (rd_data_o),
  .buf_rd_i        (buf_rd_i),
  .buf_wr_i        (buf_wr_i),
  .buf_rd_en_i     (buf_rd_en_i),
  .buf_wr_en_i     (buf_wr_en_i),
  .rsp_valid_i     (rsp_valid_i),
  .rsp_kind_i      (rsp_kind_i),
  .rsp_auto_stop_i (rsp_auto_stop_i),
  .rsp_status_i    (rsp_status_i),
  .cs_err_mask_i   (cs_err_mask_i),
  .ac12_err_i      (ac12_err_i),
  .eb_rd_valid_i   (eb_rd_valid_i),
  .eb_rd_bit_i     (eb_rd_bit_i),
  .eb_crc_valid_i  (eb_crc_valid_i),
  .eb_crc_bit_i    (eb_crc_bit_i),
  .irq_en_i        (irq_en_i),
  .irq_o           (irq_o)
);

// File: tb/cardhost_int_status_test.sv
`timescale 1ns/1ps
module cardhost_int_status_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        buf_rd = 1'b0, buf_wr = 1'b0, buf_rd_en = 1'b1, buf_wr_en = 1'b1;
  logic        rsp_valid = 1'b0, rsp_auto = 1'b0;
  logic [3:0]  rsp_kind = '0;
  logic [31:0] rsp_status = '0, cs_mask = '0;
  logic [7:0]  ac12 = '0;
  logic        eb_rd_v = 1'b0, eb_rd_b = 1'b1, eb_crc_v = 1'b0, eb_crc_b = 1'b1;
  logic [5:0]  ext_err = '0;
  logic [14:0] norm_evt = '0;
  logic [31:0] irq_en = '0;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cardhost_int_status uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .buf_rd_i(buf_rd), .buf_wr_i(buf_wr), .buf_rd_en_i(buf_rd_en), .buf_wr_en_i(buf_wr_en),
    .rsp_valid_i(rsp_valid), .rsp_kind_i(rsp_kind), .rsp_auto_stop_i(rsp_auto),
    .rsp_status_i(rsp_status), .cs_err_mask_i(cs_mask), .ac12_err_i(ac12),
    .eb_rd_valid_i(eb_rd_v), .eb_rd_bit_i(eb_rd_b), .eb_crc_valid_i(eb_crc_v), .eb_crc_bit_i(eb_crc_b),
    .ext_err_i(ext_err), .norm_evt_i(norm_evt), .irq_en_i(irq_en), .irq_o(irq)
  );

  // behavioural reference model
  logic [31:0] m_stat;
  logic [7:0]  m_ac_prev;
  always @(posedge clk or negedge rst_n) begin
    logic [31:0] s;
    if (!rst_n) begin
      m_stat    = '0;
      m_ac_prev = '0;
    end else begin
      s = '0;
      if ((buf_rd && !buf_rd_en) || (buf_wr && !buf_wr_en)) s[29] = 1'b1;
      if (rsp_valid && !rsp_auto && (rsp_status & cs_mask) != 0 &&
          (rsp_kind == 1 || rsp_kind == 2 || rsp_kind == 6 || rsp_kind == 7 || rsp_kind == 8))
        s[28] = 1'b1;
      for (int k = 0; k < 8; k++) if (ac12[k] && !m_ac_prev[k]) s[24] = 1'b1;
      m_ac_prev = ac12;
      if ((eb_rd_v && !eb_rd_b) || (eb_crc_v && !eb_crc_b)) s[22] = 1'b1;
      for (int k = 0; k < 6; k++) if (ext_err[k]) s[16+k] = 1'b1;
      for (int k = 0; k < 15; k++) if (norm_evt[k]) s[k] = 1'b1;
      if (wr_en) m_stat = m_stat & ~wr_data;
      m_stat = m_stat | s;
    end
  end

  function automatic logic [31:0] exp_rd();
    logic [31:0] r = m_stat;
    r[15] = (m_stat[31:16] != 0);
    return r;
  endfunction

  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      total++;
      if (rd_data !== exp_rd() || irq !== ((exp_rd() & irq_en) != 0)) begin
        bad++;
        $display("FAIL R2 model: rd=%h irq=%b expected rd=%h irq=%b",
                 rd_data, irq, exp_rd(), (exp_rd() & irq_en) != 0);
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic clr_all();
    nxt(); wr_en = 1'b1; wr_data = '1;
    nxt(); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rsp(input logic [3:0] kind, input logic auto_stop);
    nxt(); rsp_valid = 1'b1; rsp_kind = kind; rsp_auto = auto_stop;
    nxt(); rsp_valid = 1'b0; rsp_auto = 1'b0;
    #3;
  endtask

  initial begin
    repeat (3) nxt();
    #3 chk(rd_data, 32'h0, "R1 status in reset");
    chk({31'h0, irq}, 32'h0, "R1 irq in reset");
    nxt(); rst_n = 1'b1;
    nxt(); #3 chk(rd_data, 32'h0, "R1 status after reset");

    // R4 bad access
    nxt(); buf_rd = 1'b1; buf_rd_en = 1'b0;
    nxt(); buf_rd = 1'b0; #3 chk(rd_data[29], 1, "R4 read not permitted");
    nxt(); wr_en = 1'b1; wr_data = 32'h0 | (32'h1 << 29);
    nxt(); wr_en = 1'b0; wr_data = '0; #3 chk(rd_data[29], 0, "R2 write-1 clear");
    nxt(); buf_rd = 1'b1; buf_rd_en = 1'b1; buf_wr = 1'b1; buf_wr_en = 1'b1;
    nxt(); buf_rd = 1'b0; buf_wr = 1'b0; #3 chk(rd_data[29], 0, "R4 permitted access");
    nxt(); buf_wr = 1'b1; buf_wr_en = 1'b0;
    nxt(); buf_wr = 1'b0; buf_wr_en = 1'b1; #3 chk(rd_data[29], 1, "R4 write not permitted");
    nxt(); wr_en = 1'b1; wr_data = 32'h0;
    nxt(); wr_en = 1'b0; #3 chk(rd_data[29], 1, "R2 write-0 keeps bit");
    clr_all();

    // R5 / R6 card status
    cs_mask = 32'h0008_0000; rsp_status = 32'h0008_0010;
    rsp(4'd1, 1'b0); chk(rd_data[28], 1, "R5 R1 masked-in error");
    clr_all();
    cs_mask = 32'h0000_0001;
    rsp(4'd1, 1'b0); chk(rd_data[28], 0, "R5 masked-off error");
    cs_mask = 32'h0008_0000;
    rsp(4'd3, 1'b0); chk(rd_data[28], 0, "R5 R2 type ignored");
    rsp(4'd8, 1'b0); chk(rd_data[28], 1, "R5 R6 type sets");
    clr_all();
    rsp(4'd7, 1'b1); chk(rd_data[28], 0, "R6 auto-stop response ignored");
    rsp(4'd2, 1'b0); chk(rd_data[28], 1, "R5 R1b type sets");
    clr_all();
    cs_mask = '0; rsp_status = '0;

    // R7 auto-stop error vector edges
    nxt(); ac12 = 8'h02;
    nxt(); #3 chk(rd_data[24], 1, "R7 rising bit sets");
    clr_all();
    repeat (3) nxt();
    #3 chk(rd_data[24], 0, "R7 held bit no re-set");
    nxt(); ac12 = 8'h06;
    nxt(); #3 chk(rd_data[24], 1, "R7 second bit rises");
    clr_all();
    nxt(); ac12 = 8'h00;
    nxt(); #3 chk(rd_data[24], 0, "R7 falling edge no set");

    // R8 end bit
    nxt(); eb_rd_v = 1'b1; eb_rd_b = 1'b0;
    nxt(); eb_rd_v = 1'b0; eb_rd_b = 1'b1; #3 chk(rd_data[22], 1, "R8 read end bit 0");
    clr_all();
    nxt(); eb_rd_v = 1'b1; eb_rd_b = 1'b1; eb_crc_b = 1'b0;
    nxt(); eb_rd_v = 1'b0; #3 chk(rd_data[22], 0, "R8 good end bit / no strobe");
    eb_crc_b = 1'b1;
    nxt(); eb_crc_v = 1'b1; eb_crc_b = 1'b0;
    nxt(); eb_crc_v = 1'b0; eb_crc_b = 1'b1; #3 chk(rd_data[22], 1, "R8 crc status end bit 0");

    // R9 set wins over clear
    nxt(); eb_crc_v = 1'b1; eb_crc_b = 1'b0; wr_en = 1'b1; wr_data = 32'h0040_0000;
    nxt(); eb_crc_v = 1'b0; eb_crc_b = 1'b1; wr_en = 1'b0; wr_data = '0;
    #3 chk(rd_data[22], 1, "R9 set and clear same cycle");
    clr_all();

    // R12 / R3 / R10 / R11
    nxt(); ext_err = 6'h3F; norm_evt = 15'h7FFF;
    nxt(); ext_err = '0; norm_evt = '0; #3 chk(rd_data, 32'h003F_FFFF, "R12 generic events");
    chk(rd_data & 32'hCE80_0000, 32'h0, "R3 reserved read 0");
    nxt(); wr_en = 1'b1; wr_data = 32'h0000_8000;
    nxt(); wr_en = 1'b0; wr_data = '0; #3 chk(rd_data[15], 1, "R10 summary not writable");
    clr_all();
    nxt(); norm_evt = 15'h0001;
    nxt(); norm_evt = '0; #3 chk(rd_data[15], 0, "R10 no error no summary");
    irq_en = 32'h0000_0001; #1 chk({31'h0, irq}, 32'h1, "R11 enabled normal bit");
    irq_en = 32'h2000_0000; #1 chk({31'h0, irq}, 32'h0, "R11 disabled bit");
    nxt(); ext_err = 6'h01;
    nxt(); ext_err = '0; irq_en = 32'h0000_8000; #3 chk(rd_data[15], 1, "R10 summary follows error");
    chk({31'h0, irq}, 32'h1, "R11 summary enabled");
    clr_all();
    #3 chk(rd_data, 32'h0, "R2 clear all");
    irq_en = '0;
    repeat (2) nxt();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule